// File: doc/BRIEF.md
# Two-Wire Command-Register Slave

This block is a slave on a two-wire serial bus (open-drain clock and data lines). It holds the configuration of a programmable clock generator: a 10-bit divider value, a 9-bit mode set (prescaler selects, enable/select/power-down options and a divider bypass), and a small bus word made of a write-commit policy bit and a 3-bit device select. A master reaches a register by addressing the slave and sending a command byte. Then it either sends data bytes, or issues a repeated START with the read bit set and clocks the bytes back out.

The block keeps a nonvolatile image of the three registers. That image is modelled as a shadow copy with a busy timer. A commit happens at the end of a write transaction when the policy bit is clear, or on an explicit commit command. Any write to the bus word also forces a commit. While a commit runs, the slave refuses every byte, its own address included. Both bus lines are oversampled on the system clock. The only bus output is a pull-down enable for the data line.

Top module: `twi_cmd_slave`

## Requirements
- R1: After reset the divider value is 0, the mode output is 9'h060 (select-option and enable-option bits set, everything else clear), the policy bit is 0, the device select is 3'b000 and the data line is released.
- R2: The slave acknowledges an address byte only when bits 7:4 are 4'b1011 and bits 3:1 equal the stored device select, with bit 0 giving the direction (1 = read). After a refused address it ignores every following byte until the next START or STOP.
- R3: Command 8'h01 selects the divider. The first data byte loads value bits 9:2, and bits 7:6 of the second data byte load value bits 1:0.
- R4: Command 8'h02 selects the mode set. The first data byte loads, from bit 6 down to bit 0, the two power-down options, the select option, the enable option, the two-bit output-0 prescaler code and the upper bit of the output-1 prescaler code. Bit 7 of that byte is ignored and reads back as 0. Bit 7 of the second data byte is the lower bit of the output-1 prescaler code, and bit 6 is the divider bypass. The mode output is ordered {pdn1, pdn0, sel0, en0, p0[1:0], p1[1:0], bypass}.
- R5: Command 8'h0D selects the bus word. Data bits 3 and 2:0 load the policy bit and the device select. A new select governs the next address byte.
- R6: Sending only the first data byte of a two-byte register and then STOP changes that byte's bits alone.
- R7: A read returns the selected register's bytes in the write layout, MSB first, with unused bits as 0. A master ACK advances to the next byte. After a master NACK the slave releases the data line.
- R8: With the policy bit clear, a transaction that wrote a register starts a commit at its STOP or repeated START. During the busy time every byte is refused, and the address is accepted again once the busy time has passed.
- R9: With the policy bit set, register writes start no commit, and command 8'h3F starts one as soon as it is accepted.
- R10: A write to the bus word starts a commit as soon as it is accepted, whatever the policy bit.
- R11: The slave asserts the data pull-down only while the sampled clock is low, and releases it on any START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | High to pull the data line low |
| div_n_o | output | 10 | Divider value (divisor minus two) |
| mode_o | output | 9 | Mode set {pdn1, pdn0, sel0, en0, p0[1:0], p1[1:0], bypass} |
| wc_o | output | 1 | Write-commit policy bit |
| dev_sel_o | output | 3 | Device select compared against address bits 3:1 |

## Verification
A wrong byte counter or a wrong protocol state shows on the data line within one byte time. It appears as a missing or misplaced acknowledge, or as read data shifted by one bit. A wrong write decode shows on the register outputs as soon as the data byte is acknowledged. A wrong commit decision does not change any register. It shows only as a refused or accepted address in the next transaction, within the busy time. The bench therefore probes the address acknowledge immediately after each commit trigger and again after the busy time.

// File: rtl/twi_cfg_pkg.sv
package twi_cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_CMD,
        ST_DATA,
        ST_TX,
        ST_TXACK
    } twi_state_e;

    localparam logic [7:0] CMD_DIV    = 8'h01;
    localparam logic [7:0] CMD_MODE   = 8'h02;
    localparam logic [7:0] CMD_BUS    = 8'h0D;
    localparam logic [7:0] CMD_COMMIT = 8'h3F;

    localparam int DIV_W  = 10;
    localparam int MODE_W = 9;
    localparam int SEL_W  = 3;

    localparam logic [MODE_W-1:0] MODE_RESET = 9'h060;

    typedef struct packed {
        logic [DIV_W-1:0]  div_n;
        logic [MODE_W-1:0] mode;
        logic              wc;
        logic [SEL_W-1:0]  sel;
    } cfg_image_t;

    // Byte presented on a read for a given command and byte position.
    function automatic logic [7:0] cfg_read_byte(cfg_image_t img, logic [7:0] cmd,
                                                 logic [1:0] idx);
        logic [7:0] b;
        b = 8'h00;
        case (cmd)
            CMD_DIV: begin
                if (idx == 2'd0) b = img.div_n[9:2];
                else if (idx == 2'd1) b = {img.div_n[1:0], 6'b0};
            end
            CMD_MODE: begin
                if (idx == 2'd0) b = {1'b0, img.mode[8:2]};
                else if (idx == 2'd1) b = {img.mode[1:0], 6'b0};
            end
            CMD_BUS: begin
                if (idx == 2'd0) b = {4'b0, img.wc, img.sel};
            end
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[SYNC_STAGES-1];
    assign sda_s     = sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign start_det = scl_s && scl_q && sda_q && !sda_s;
    assign stop_det  = scl_s && scl_q && !sda_q && sda_s;

endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
    import twi_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wr_cmd,
    input  logic [1:0] wr_idx,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_cmd,
    input  logic [1:0] rd_idx,
    output cfg_image_t img,
    output logic [7:0] rd_byte
);
    always_ff @(posedge clk) begin
        if (rst) begin
            img.div_n <= '0;
            img.mode  <= MODE_RESET;
            img.wc    <= 1'b0;
            img.sel   <= '0;
        end else if (wr_en) begin
            case (wr_cmd)
                CMD_DIV: begin
                    if (wr_idx == 2'd0) img.div_n[9:2] <= wr_data;
                    else if (wr_idx == 2'd1) img.div_n[1:0] <= wr_data[7:6];
                end
                CMD_MODE: begin
                    if (wr_idx == 2'd0) img.mode[8:2] <= wr_data[6:0];
                    else if (wr_idx == 2'd1) img.mode[1:0] <= wr_data[7:6];
                end
                CMD_BUS: begin
                    if (wr_idx == 2'd0) {img.wc, img.sel} <= wr_data[3:0];
                end
                default: ;
            endcase
        end
    end

    assign rd_byte = cfg_read_byte(img, rd_cmd, rd_idx);

    AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(img)); // R3

endmodule

// File: rtl/twi_nv_store.sv
module twi_nv_store
    import twi_cfg_pkg::*;
#(
    parameter int BUSY_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       commit_req,
    input  cfg_image_t img,
    output logic       busy
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt;
    cfg_image_t    shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt        <= '0;
            shadow.div_n <= '0;
            shadow.mode  <= MODE_RESET;
            shadow.wc    <= 1'b0;
            shadow.sel   <= '0;
        end else if (commit_req && !busy) begin
            shadow <= img;
            cnt    <= CW'(BUSY_CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit_req)); // R8

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (commit_req && !busy) |=> (shadow == $past(img))); // R10

endmodule

// File: rtl/twi_cmd_slave.sv
module twi_cmd_slave
    import twi_cfg_pkg::*;
#(
    parameter logic [3:0] DEV_CODE    = 4'b1011,
    parameter int         SYNC_STAGES = 2,
    parameter int         BUSY_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_pull_o,
    output logic [9:0] div_n_o,
    output logic [8:0] mode_o,
    output logic       wc_o,
    output logic [2:0] dev_sel_o
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twi_state_e state, nxt;
    logic [7:0] shreg;
    logic [3:0] bcnt;
    logic [7:0] cmd_q;
    logic [1:0] byte_idx;
    logic       mack;
    logic       dirty;
    logic       sda_pull;

    cfg_image_t img;
    logic [7:0] rd_byte;
    logic       busy;

    // Byte boundary: eighth bit clocked, clock now falling.
    logic byte_done, addr_match, byte_ok;
    logic wr_en, commit_req, end_of_xfer;

    assign byte_done  = scl_fall && (bcnt == 4'd8);
    assign addr_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == img.sel);
    assign byte_ok    = !busy && ((state != ST_ADDR) || addr_match);
    assign wr_en      = byte_done && (state == ST_DATA) && !busy;
    assign end_of_xfer = start_det || stop_det;
    assign commit_req = (wr_en && (cmd_q == CMD_BUS) && (byte_idx == 2'd0))
                      || (byte_done && (state == ST_CMD) && !busy && (shreg == CMD_COMMIT))
                      || (end_of_xfer && dirty && !img.wc);

    twi_reg_bank u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_cmd(cmd_q), .wr_idx(byte_idx),
        .wr_data(shreg), .rd_cmd(cmd_q), .rd_idx(byte_idx), .img(img), .rd_byte(rd_byte)
    );

    twi_nv_store #(.BUSY_CYCLES(BUSY_CYCLES)) u_store (
        .clk(clk), .rst(rst), .commit_req(commit_req), .img(img), .busy(busy)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            nxt      <= ST_IDLE;
            shreg    <= '0;
            bcnt     <= '0;
            cmd_q    <= '0;
            byte_idx <= '0;
            mack     <= 1'b0;
            dirty    <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            if (commit_req || end_of_xfer) dirty <= 1'b0;
            else if (wr_en && (cmd_q != CMD_BUS)) dirty <= 1'b1;

            if (start_det) begin
                state    <= ST_ADDR;
                bcnt     <= '0;
                sda_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                bcnt     <= '0;
                sda_pull <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CMD, ST_DATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_s};
                            bcnt  <= bcnt + 4'd1;
                        end else if (byte_done) begin
                            bcnt <= '0;
                            if (byte_ok) begin
                                sda_pull <= 1'b1;
                                state    <= ST_ACK;
                                case (state)
                                    ST_ADDR: begin
                                        nxt      <= shreg[0] ? ST_TX : ST_CMD;
                                        byte_idx <= '0;
                                    end
                                    ST_CMD: begin
                                        nxt      <= ST_DATA;
                                        cmd_q    <= shreg;
                                        byte_idx <= '0;
                                    end
                                    default: begin
                                        nxt <= ST_DATA;
                                        if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                                    end
                                endcase
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            bcnt  <= '0;
                            state <= nxt;
                            if (nxt == ST_TX) begin
                                shreg    <= rd_byte;
                                sda_pull <= !rd_byte[7];
                            end else begin
                                sda_pull <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) begin
                            bcnt <= bcnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bcnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                bcnt     <= '0;
                                state    <= ST_TXACK;
                                if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                            end else begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= !shreg[6];
                            end
                        end
                    end
                    ST_TXACK: begin
                        if (scl_rise) begin
                            mack <= !sda_s;
                        end else if (scl_fall) begin
                            if (mack) begin
                                shreg    <= rd_byte;
                                sda_pull <= !rd_byte[7];
                                state    <= ST_TX;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_pull_o = sda_pull;
    assign div_n_o    = img.div_n;
    assign mode_o     = img.mode;
    assign wc_o       = img.wc;
    assign dev_sel_o  = img.sel;

    AST_PULL_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_pull) |-> !scl_s); // R11

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
        stop_det |=> !sda_pull); // R11

    AST_MASTER_ACK_SLOT_FREE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TXACK) |-> !sda_pull); // R7

    AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        (byte_done && busy && state != ST_TX) |=> !sda_pull); // R8

endmodule

// File: tb/twi_cmd_slave_tb.sv
module twi_cmd_slave_tb;
    localparam int Q    = 5;
    localparam int BUSY = 400;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic [9:0] div_n;
    logic [8:0] mode;
    logic       wc;
    logic [2:0] dev_sel;
    wire        sda_line = sda_m & ~sda_pull;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    twi_cmd_slave #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .div_n_o(div_n), .mode_o(mode),
        .wc_o(wc), .dev_sel_o(dev_sel)
    );

    // cmd, byte0, byte1, expected port value, readback byte0, readback byte1
    localparam int NV = 7;
    localparam logic [55:0] VEC [NV] = '{
        {8'h01, 8'hFF, 8'hC0, 16'h03FF, 8'hFF, 8'hC0},
        {8'h01, 8'h81, 8'h40, 16'h0205, 8'h81, 8'h40},
        {8'h01, 8'h12, 8'h3F, 16'h0048, 8'h12, 8'h00},
        {8'h02, 8'hFF, 8'hFF, 16'h01FF, 8'h7F, 8'hC0},
        {8'h02, 8'h2A, 8'h80, 16'h00AA, 8'h2A, 8'h80},
        {8'h01, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00},
        {8'h02, 8'h18, 8'h00, 16'h0060, 8'h18, 8'h00}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic got);
        sda_m = b;  wq(Q);
        scl_m = 1'b1; wq(Q);
        got = sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic g;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], g);
        clk_bit(1'b1, g);
        ack = !g;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] d);
        logic g;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, g);
            d[i] = g;
        end
        clk_bit(!give_ack, g);
    endtask

    function automatic logic [7:0] addr(input logic [2:0] sel, input logic rd);
        return {4'b1011, sel, rd};
    endfunction

    function automatic int observe(input logic [7:0] cmd);
        case (cmd)
            8'h01: return int'(div_n);
            8'h02: return int'(mode);
            default: return int'({wc, dev_sel});
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic a0, a1, a2, a3;
        logic [7:0] r0, r1;
        logic [2:0] sel;
        sel = 3'b000;
        wq(4);
        rst = 1'b0;
        wq(4);

        // R1 reset state
        check(div_n == 10'd0, "R1 div", div_n, 0);
        check(mode == 9'h060, "R1 mode", mode, 9'h060);
        check(wc == 1'b0, "R1 wc", wc, 0);
        check(dev_sel == 3'd0, "R1 sel", dev_sel, 0);
        check(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);

        // Table: write, check port, read back (R3, R4, R7, R8)
        for (int v = 0; v < NV; v++) begin
            logic [7:0] c, b0, b1, e0, e1;
            logic [15:0] ev;
            {c, b0, b1, ev, e0, e1} = VEC[v];
            bus_start();
            send_byte(addr(sel, 1'b0), a0);
            send_byte(c, a1);
            send_byte(b0, a2);
            send_byte(b1, a3);
            bus_stop();
            check(a0 && a1 && a2 && a3, "R3/R4 write acks", {a0, a1, a2, a3}, 4'hF);
            check(observe(c) == int'(ev), (c == 8'h01) ? "R3 divider" : "R4 mode",
                  observe(c), ev);
            wq(BUSY + 200);
            bus_start();
            send_byte(addr(sel, 1'b0), a0);
            send_byte(c, a1);
            bus_start();
            send_byte(addr(sel, 1'b1), a2);
            recv_byte(1'b1, r0);
            recv_byte(1'b0, r1);
            wq(2);
            check(sda_pull == 1'b0, "R7 released after master NACK", sda_pull, 0);
            bus_stop();
            check(a0 && a1 && a2, "R7 read acks", {a0, a1, a2}, 3'h7);
            check(r0 == e0, "R7 readback byte0", r0, e0);
            check(r1 == e1, "R7 readback byte1", r1, e1);
            wq(20);
        end

        // R2 wrong device code, later bytes ignored
        bus_start();
        send_byte(8'hA0, a0);
        send_byte(8'h01, a1);
        send_byte(8'h55, a2);
        bus_stop();
        check(!a0, "R2 wrong code refused", a0, 0);
        check(!a1 && !a2, "R2 bytes after refusal not acked", {a1, a2}, 0);
        check(div_n == 10'd0, "R2 divider untouched", div_n, 0);
        bus_start();
        send_byte(addr(3'b001, 1'b0), a0);
        bus_stop();
        check(!a0, "R2 wrong select refused", a0, 0);

        // R6 partial write, then R8 busy window
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        send_byte(8'h01, a1);
        send_byte(8'hFF, a2);
        send_byte(8'hC0, a3);
        bus_stop();
        wq(BUSY + 200);
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        send_byte(8'h01, a1);
        send_byte(8'h00, a2);
        bus_stop();
        check(div_n == 10'h003, "R6 MSB-only write", div_n, 10'h003);
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        bus_stop();
        check(!a0, "R8 address refused while committing", a0, 0);
        wq(BUSY + 200);
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        bus_stop();
        check(a0, "R8 address accepted after commit", a0, 1);

        // R5/R10 bus word write with WC=0: commit at once
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        send_byte(8'h0D, a1);
        send_byte(8'h0A, a2);
        send_byte(8'h00, a3);
        bus_stop();
        check(a2 && !a3, "R10 byte after bus write refused", {a2, a3}, 2'b10);
        check(wc == 1'b1 && dev_sel == 3'b010, "R5 bus word", {wc, dev_sel}, 4'hA);
        wq(BUSY + 200);
        bus_start();
        send_byte(addr(3'b000, 1'b0), a0);
        bus_stop();
        check(!a0, "R5 old select refused", a0, 0);
        sel = 3'b010;
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        bus_stop();
        check(a0, "R5 new select accepted", a0, 1);

        // R9 WC=1: write without commit, then explicit commit
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        send_byte(8'h01, a1);
        send_byte(8'h55, a2);
        send_byte(8'h40, a3);
        bus_stop();
        check(div_n == 10'h155, "R9 divider written", div_n, 10'h155);
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        check(a0, "R9 no commit after write with WC=1", a0, 1);
        send_byte(8'h3F, a1);
        send_byte(8'h00, a2);
        bus_stop();
        check(a1 && !a2, "R9 commit command starts busy", {a1, a2}, 2'b10);
        wq(BUSY + 200);

        // R10 bus write commits even with WC=1
        bus_start();
        send_byte(addr(sel, 1'b0), a0);
        send_byte(8'h0D, a1);
        send_byte(8'h0A, a2);
        send_byte(8'h00, a3);
        bus_stop();
        check(a0 && a1 && a2 && !a3, "R10 commit with WC=1", {a0, a1, a2, a3}, 4'hE);
        check(sda_pull == 1'b0, "R11 released after STOP", sda_pull, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule